// File: doc/BRIEF.md
# Clock Generator Power-State Sequencer

This block sequences a multi-output clock generator through power-up and power-down. After the supply detector reports good power it enables the PLL and waits for the active-low power-good qualifier. When the qualifier goes low it captures the frequency-select straps and then counts a settling delay in timebase ticks before it turns on every output group together.

An asynchronous active-low power-down request is synchronised into the sequencer clock. It is accepted only after it has been seen low on two consecutive rising edges of the CPU complement clock. Each clock group then halts low on one of its own falling edges, with the fixed PCI group first and the buffered 66 MHz group after it. The CPU pair halts with its true output high. The PLL is switched off only after the last group has halted. When the request is released, the PLL restarts and the outputs return after a lock wait.

All source clocks are sampled by the fast sequencer clock `clk`, and every edge decision is made in that domain. The delays are tick counts given as parameters: with a 1 µs tick the defaults of 250 and 1000 ticks give a 0.25 ms settle and a 1 ms relock, which stays inside a 3 ms restart budget.

Top module: `clkseq_top`

## Requirements
- R1: When `supply_ok` is low, the block returns to the off state within three clock cycles, passing through its two-stage synchroniser. In the off state every bit of `grp_run`, `cpu_run`, `pll_en` and `regif_en` is low. `regif_en` is high in every other state.
- R2: `straps_q` resets to 0. It loads `strap_in` once per power-up, in the cycle after the synchronised `pg_n` is first seen low while the block waits for the qualifier. At any other time a change on `strap_in` leaves `straps_q` unchanged.
- R3: After the straps are captured, all `grp_run` bits and `cpu_run` rise together once SETTLE_TICKS `tick` pulses have been counted. They do not rise before that.
- R4: `pd_n` is synchronised, and a stop sequence begins only after it has been sampled low on two consecutive rising edges of `cpu_c_clk`. A low pulse that covers fewer such edges has no effect on any output.
- R5: In a stop sequence, `grp_run[0]` (fixed PCI group) clears on the next falling edge of `grp_clk[0]`. `grp_run[1]` (buffered 66 MHz group) clears on the first falling edge of `grp_clk[1]` after bit 0 has cleared, so it is strictly later. Each higher group clears on its own next falling edge. Every bit clears while its own clock is low.
- R6: `cpu_run` clears on a falling edge of `cpu_c_clk`, so the true CPU output is high at that point. A low `cpu_run` means the true output is parked high and the complement is undriven.
- R7: `pll_en` never goes low while any of `grp_run` or `cpu_run` is high. It drops within two cycles after the last of them clears.
- R8: After `pd_n` returns high, `pll_en` rises again. All run enables come back together after LOCK_TICKS ticks, and not before.
- R9: A power-down recognised before normal operation is held. The outputs first come up as in R3, and the stop sequence then runs as in R5 to R7.
- R10: `pll_en` is high in every state from supply detection onward, except in the powered-down state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, faster than every sampled source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply detector result, high when power is good |
| pg_n | input | 1 | Active-low power-good qualifier |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| tick | input | 1 | One-cycle timebase pulse used for delays |
| strap_in | input | STRAP_W | Frequency-select strap pins |
| cpu_c_clk | input | 1 | CPU complement clock |
| grp_clk | input | NGRP | Clocks of the non-CPU groups; bit 0 fixed PCI, bit 1 buffered 66 MHz |
| grp_run | output | NGRP | Run enable for each non-CPU group |
| cpu_run | output | 1 | Run enable for the CPU pair |
| pll_en | output | 1 | PLL and VCO enable |
| straps_q | output | STRAP_W | Latched strap value |
| regif_en | output | 1 | Enable for the register-interface logic |

## Verification
The collision of interest is a power-down recognised while the settling count is still running, so that the end of the count and the pending request meet at the entry to normal operation. The bench provokes it on half of its power cycles by lowering `pd_n` one tick before the count ends. It then judges that the outputs did not come up early, that they were seen fully enabled at least once, and that the stop order and the late PLL shutdown still held. The other half of the sweep asserts power-down at a range of clock phases during normal operation, and one run sends a pulse too short to be recognised.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_SUPPLY,
    ST_LATCH,
    ST_SETTLE,
    ST_RUN,
    ST_STOP,
    ST_PD,
    ST_RELOCK
  } seq_state_e;
endpackage

// File: rtl/clkseq_sync.sv
module clkseq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkseq_edge.sv
module clkseq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic fall
);
  logic prev;

  clkseq_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign fall = prev & ~lvl;
endmodule

// File: rtl/clkseq_tickcnt.sv
module clkseq_tickcnt #(
  parameter int LIMIT = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clear)              cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/clkseq_pdrecog.sv
module clkseq_pdrecog (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pd_s,
  input  logic cpu_lvl,
  output logic recog
);
  logic       cpu_prev;
  logic [1:0] lowcnt;
  logic       rise;

  assign rise  = cpu_lvl & ~cpu_prev;
  assign recog = en & rise & ~pd_s & (lowcnt == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_prev <= 1'b0;
      lowcnt   <= '0;
    end else begin
      cpu_prev <= cpu_lvl;
      if (!en)        lowcnt <= '0;
      else if (rise) begin
        if (pd_s)                lowcnt <= '0;
        else if (lowcnt != 2'd2) lowcnt <= lowcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkseq_top.sv
module clkseq_top
  import clkseq_pkg::*;
#(
  parameter int NGRP         = 4,
  parameter int STRAP_W      = 3,
  parameter int SETTLE_TICKS = 250,
  parameter int LOCK_TICKS   = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               supply_ok,
  input  logic               pg_n,
  input  logic               pd_n,
  input  logic               tick,
  input  logic [STRAP_W-1:0] strap_in,
  input  logic               cpu_c_clk,
  input  logic [NGRP-1:0]    grp_clk,
  output logic [NGRP-1:0]    grp_run,
  output logic               cpu_run,
  output logic               pll_en,
  output logic [STRAP_W-1:0] straps_q,
  output logic               regif_en
);
  seq_state_e state, state_nx;
  logic sup_s, pg_s, pd_s;
  logic cpu_lvl, cpu_fall;
  logic [NGRP-1:0] g_lvl, g_fall, run_q;
  logic cpu_q, pd_req, recog, settle_done, lock_done, enable_all, all_off;

  clkseq_sync #(.W(3), .STAGES(2), .RST_VAL(3'b011)) u_insync (
    .clk(clk), .rst_n(rst_n),
    .d({supply_ok, pg_n, pd_n}), .q({sup_s, pg_s, pd_s})
  );

  clkseq_edge u_cpu_edge (
    .clk(clk), .rst_n(rst_n), .din(cpu_c_clk), .lvl(cpu_lvl), .fall(cpu_fall)
  );

  clkseq_pdrecog u_recog (
    .clk(clk), .rst_n(rst_n), .en(state != ST_OFF),
    .pd_s(pd_s), .cpu_lvl(cpu_lvl), .recog(recog)
  );

  clkseq_tickcnt #(.LIMIT(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst_n(rst_n), .clear(state != ST_SETTLE), .tick(tick), .done(settle_done)
  );

  clkseq_tickcnt #(.LIMIT(LOCK_TICKS)) u_lock (
    .clk(clk), .rst_n(rst_n), .clear(state != ST_RELOCK), .tick(tick), .done(lock_done)
  );

  assign enable_all = (state == ST_SETTLE && settle_done) ||
                      (state == ST_RELOCK && lock_done);
  assign all_off    = (run_q == '0) && !cpu_q;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_OFF:    if (sup_s) state_nx = ST_SUPPLY;
      ST_SUPPLY: if (!pg_s) state_nx = ST_LATCH;
      ST_LATCH:  state_nx = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_nx = ST_RUN;
      ST_RUN:    if (pd_req) state_nx = ST_STOP;
      ST_STOP:   if (all_off) state_nx = ST_PD;
      ST_PD:     if (pd_s) state_nx = ST_RELOCK;
      ST_RELOCK: if (lock_done) state_nx = ST_RUN;
      default:   state_nx = ST_OFF;
    endcase
    if (!sup_s) state_nx = ST_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      pd_req   <= 1'b0;
      straps_q <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_OFF)                  pd_req <= 1'b0;
      else if (recog)                       pd_req <= 1'b1;
      else if (state == ST_RUN && pd_req)   pd_req <= 1'b0;
      if (state == ST_LATCH) straps_q <= strap_in;
    end
  end

  for (genvar i = 0; i < NGRP; i++) begin : g_grp
    clkseq_edge u_edge (
      .clk(clk), .rst_n(rst_n), .din(grp_clk[i]), .lvl(g_lvl[i]), .fall(g_fall[i])
    );

    // group 1 waits for group 0; all others stop independently
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   run_q[i] <= 1'b0;
      else if (!sup_s || state == ST_OFF) run_q[i] <= 1'b0;
      else if (enable_all)          run_q[i] <= 1'b1;
      else if (state == ST_STOP && g_fall[i] && (i != 1 || !run_q[0]))
                                    run_q[i] <= 1'b0;
    end

    a_r5_stop_while_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q[i]) && $past(state == ST_STOP) |-> !$past(g_lvl[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cpu_q <= 1'b0;
    else if (!sup_s || state == ST_OFF) cpu_q <= 1'b0;
    else if (enable_all)                cpu_q <= 1'b1;
    else if (state == ST_STOP && cpu_fall) cpu_q <= 1'b0;
  end

  assign grp_run  = run_q;
  assign cpu_run  = cpu_q;
  assign pll_en   = (state != ST_OFF) && (state != ST_PD);
  assign regif_en = (state != ST_OFF);

  a_r7_pll_after_groups: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) && $past(sup_s) |-> ($past(grp_run) == '0) && !$past(cpu_run));

  a_r5_pci_before_66: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q[1]) && $past(state == ST_STOP) |-> !$past(run_q[0]));

  a_r6_cpu_true_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_q) && $past(state == ST_STOP) |-> !$past(cpu_lvl));

  a_r2_straps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_LATCH |=> $stable(straps_q));

  a_r1_off_on_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_s |=> state == ST_OFF && !regif_en);
endmodule

// File: tb/sim_clkseq_top.sv
`timescale 1ns/1ps
module sim_clkseq_top;
  localparam int NG = 4;
  localparam int SW = 3;
  localparam int SETTLE = 5;
  localparam int LOCK = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, pg_n = 1'b1, pd_n = 1'b1, tick = 1'b0;
  logic [SW-1:0] strap_in = '0;
  logic cpu_c_clk = 1'b0;
  logic [NG-1:0] grp_clk = '0;
  logic [NG-1:0] grp_run;
  logic cpu_run, pll_en, regif_en;
  logic [SW-1:0] straps_q;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clkseq_top #(.NGRP(NG), .STRAP_W(SW), .SETTLE_TICKS(SETTLE), .LOCK_TICKS(LOCK)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pg_n(pg_n), .pd_n(pd_n),
    .tick(tick), .strap_in(strap_in), .cpu_c_clk(cpu_c_clk), .grp_clk(grp_clk),
    .grp_run(grp_run), .cpu_run(cpu_run), .pll_en(pll_en), .straps_q(straps_q),
    .regif_en(regif_en)
  );

  // source clocks: half periods in sequencer cycles
  int rises = 0;
  initial begin
    int half [NG] = '{5, 6, 7, 9};
    int gcnt [NG] = '{0, 0, 0, 0};
    int ccnt = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < NG; i++) begin
        if (gcnt[i] == half[i] - 1) begin grp_clk[i] = ~grp_clk[i]; gcnt[i] = 0; end
        else gcnt[i]++;
      end
      if (ccnt == 3) begin
        cpu_c_clk = ~cpu_c_clk; ccnt = 0;
        if (cpu_c_clk && !pd_n) rises++;
      end else ccnt++;
    end
  end

  // monitor, sampled 1 ns after each rising edge
  int cyc = 0;
  bit mon_on = 0, all_high_seen = 0;
  int drop_t [NG];
  int cpu_drop_t = -1, first_rises = -1, lowclk_bad = 0, pll_bad = 0;
  logic [NG-1:0] prev_grp = '0;
  logic prev_cpu = 1'b0;
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (mon_on) begin
        for (int i = 0; i < NG; i++)
          if (prev_grp[i] && !grp_run[i]) begin
            drop_t[i] = cyc;
            if (grp_clk[i]) lowclk_bad++;
            if (first_rises < 0) first_rises = rises;
          end
        if (prev_cpu && !cpu_run) begin
          cpu_drop_t = cyc;
          if (cpu_c_clk) lowclk_bad++;
          if (first_rises < 0) first_rises = rises;
        end
      end
      if (!pll_en && (grp_run != '0 || cpu_run)) pll_bad++;
      if (grp_run == '1 && cpu_run) all_high_seen = 1;
      prev_grp = grp_run;
      prev_cpu = cpu_run;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    wait_n(1);
  endtask

  task automatic mon_reset();
    for (int i = 0; i < NG; i++) drop_t[i] = -1;
    cpu_drop_t = -1; first_rises = -1; lowclk_bad = 0;
    rises = 0; mon_on = 1;
  endtask

  task automatic check_stop_phase(input int k);
    for (int w = 0; w < 400 && pll_en; w++) @(negedge clk);
    mon_on = 0;
    chk(pll_en == 1'b0, "R7 pll off after stop", pll_en, 0);
    chk(pll_bad == 0, "R7 pll low while a group ran", pll_bad, 0);
    chk(first_rises >= 2, "R4 two complement rises before stop", first_rises, 2);
    chk(drop_t[0] > 0 && drop_t[1] > drop_t[0], "R5 group1 after group0", drop_t[1], drop_t[0] + 1);
    chk(drop_t[2] > 0 && drop_t[3] > 0, "R5 other groups stopped", drop_t[2] > 0 && drop_t[3] > 0, 1);
    chk(lowclk_bad == 0, "R5 R6 halted while own clock low", lowclk_bad, 0);
    chk(cpu_drop_t > 0 && !cpu_run, "R6 cpu parked", cpu_run, 0);
    if (k < 0) $display("unreachable");
  endtask

  initial begin
    logic [SW-1:0] prev_straps;
    wait_n(3);
    chk(grp_run == '0 && !cpu_run && !pll_en && !regif_en && straps_q == '0,
        "R1 R2 reset state", {grp_run, cpu_run, pll_en, regif_en, straps_q}, 0);
    rst_n = 1'b1;
    prev_straps = '0;

    for (int k = 0; k < 8; k++) begin
      // power off
      supply_ok = 1'b0; pd_n = 1'b1; pg_n = 1'b1;
      wait_n(6);
      chk(grp_run == '0 && !cpu_run && !pll_en && !regif_en, "R1 off state",
          {grp_run, cpu_run, pll_en, regif_en}, 0);
      // supply detected, qualifier still high
      supply_ok = 1'b1; strap_in = SW'(k);
      wait_n(6);
      chk(regif_en && pll_en, "R1 R10 supply detected", {regif_en, pll_en}, 3);
      chk(straps_q == prev_straps, "R2 no capture before qualifier", straps_q, prev_straps);
      // qualifier low: capture straps
      pg_n = 1'b0;
      wait_n(8);
      chk(straps_q == SW'(k), "R2 straps captured", straps_q, k);
      strap_in = ~SW'(k);
      for (int t = 0; t < SETTLE - 1; t++) pulse_tick();
      chk(grp_run == '0 && !cpu_run, "R3 not enabled early", {grp_run, cpu_run}, 0);
      if (k % 2 == 1) begin
        // power-down during settle: held
        mon_reset();
        pd_n = 1'b0;
        wait_n(20);
        chk(grp_run == '0 && !cpu_run && pll_en, "R9 held while settling",
            {grp_run, cpu_run, pll_en}, 1);
        all_high_seen = 0;
        pulse_tick();
        wait_n(2);
        chk(all_high_seen, "R9 outputs came up before stop", all_high_seen, 1);
        check_stop_phase(k);
      end else begin
        pulse_tick();
        chk(grp_run == '1 && cpu_run, "R3 enabled after settle", {grp_run, cpu_run}, 31);
        chk(straps_q == SW'(k), "R2 strap change ignored", straps_q, k);
        if (k == 2) begin
          pd_n = 1'b0; wait_n(3); pd_n = 1'b1;
          wait_n(40);
          chk(grp_run == '1 && cpu_run && pll_en, "R4 short pulse ignored",
              {grp_run, cpu_run, pll_en}, 63);
        end
        wait_n(k);
        mon_reset();
        pd_n = 1'b0;
        check_stop_phase(k);
      end
      // release and relock
      pd_n = 1'b1;
      wait_n(8);
      chk(pll_en && grp_run == '0 && !cpu_run, "R8 pll restarts first",
          {pll_en, grp_run, cpu_run}, 32);
      for (int t = 0; t < LOCK - 1; t++) pulse_tick();
      chk(grp_run == '0 && !cpu_run, "R8 not enabled before lock", {grp_run, cpu_run}, 0);
      pulse_tick();
      chk(grp_run == '1 && cpu_run && pll_en, "R8 outputs restored",
          {grp_run, cpu_run, pll_en}, 63);
      prev_straps = SW'(k);
    end

    supply_ok = 1'b0;
    wait_n(5);
    chk(grp_run == '0 && !cpu_run && !pll_en && !regif_en, "R1 supply loss while running",
        {grp_run, cpu_run, pll_en, regif_en}, 0);
    chk(straps_q == 3'd7, "R2 straps kept through off", straps_q, 7);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule